// File: doc/BRIEF.md
# MMU Coprocessor Control Register File

This block holds the memory-management control registers that the processor core reads and writes with coprocessor move instructions. Each access gives a 4-bit register number, a 3-bit opcode_2 selector and a 4-bit CRm field, together with a write strobe and 32-bit data or a read strobe. Every stored register keeps only its architected bits and comes out of reset at a fixed value. The identification slot and the control slot each hold two registers, and opcode_2 chooses between them.

Two register numbers store nothing. A write to the cache-maintenance number (7) or the TLB-maintenance number (8) is decoded from opcode_2 and CRm into a single-cycle command pulse for the instruction cache, the data cache, the write buffer or one of the two TLBs. Per-line and per-entry commands bring the written value out on an address output. A combination that is not listed raises a one-cycle illegal flag. Three bits of the main control register drive the MMU enable, alignment check and data-cache enable outputs directly. Translation, cache storage and table walks sit in other blocks.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: On register 0, a read with opcode_2 = 0 returns `core_id`, and any nonzero opcode_2 returns the constant 0x0B1AA1AA. On register 1, opcode_2 = 0 reads and writes the main control register, and a nonzero opcode_2 reads and writes the auxiliary control register.
- R2: A write stores only these bits: main control 0x00003FFF, auxiliary control 0x00000033, table base (reg 2) 0xFFFFC000, fault status (reg 5) 0x000006FF, process ID (reg 13) 0xFE000000, coprocessor access (reg 15) 0x000003FF. Domain access (reg 3) and fault address (reg 6) store all 32 bits.
- R3: After reset, table base and domain access read 0xDEADC0DE. Every other stored register reads 0.
- R4: A write to register 7 issues a pulse chosen by {opcode_2, CRm}. {0,7} invalidates both caches. {0,5} invalidates the whole I-cache. {1,5} invalidates one I-cache line. {0,6} invalidates the whole D-cache. {1,6} invalidates one D-cache line. {1,0xA} cleans one D-cache line. {4,0xA} drains the write buffer.
- R5: A write to register 8 issues a pulse chosen by {opcode_2, CRm}. {0,7} invalidates both TLBs. {0,5} invalidates the whole I-TLB. {1,5} invalidates one I-TLB entry. {0,6} invalidates the whole D-TLB. {1,6} invalidates one D-TLB entry.
- R6: On register 7, {6,5} (branch-target-buffer invalidate) is accepted with no pulse and no illegal flag, and {5,2} invalidates the whole D-cache.
- R7: Every per-line or per-entry pulse appears together with `maint_addr` equal to the data written in that access.
- R8: A read of an unknown register number, or of register 7 or 8, returns 0. A write to an unknown number, or a maintenance write, changes no stored register.
- R9: A write to register 7 or 8 with a combination not listed in R4 to R6 raises `illegal_op` for one cycle and issues no command pulse.
- R10: Main control bit 0 drives `mmu_en`, bit 1 drives `align_en` and bit 2 drives `dcache_en`.
- R11: Command pulses and `illegal_op` appear in the cycle after the write and last exactly one cycle. `rd_data` updates in the cycle after `rd_en` and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_num | input | 4 | Coprocessor register number |
| opc2 | input | 3 | opcode_2 selector |
| crm | input | 4 | CRm field |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| core_id | input | 32 | Core identification value returned by register 0 |
| rd_data | output | 32 | Registered read data |
| mmu_en | output | 1 | MMU enable (control bit 0) |
| align_en | output | 1 | Alignment check enable (control bit 1) |
| dcache_en | output | 1 | Data-cache enable (control bit 2) |
| ic_inv_all | output | 1 | Invalidate whole I-cache |
| ic_inv_line | output | 1 | Invalidate one I-cache line |
| dc_inv_all | output | 1 | Invalidate whole D-cache |
| dc_inv_line | output | 1 | Invalidate one D-cache line |
| dc_clean_line | output | 1 | Clean one D-cache line |
| wb_drain | output | 1 | Drain the write buffer |
| itlb_inv_all | output | 1 | Invalidate whole I-TLB |
| itlb_inv_entry | output | 1 | Invalidate one I-TLB entry |
| dtlb_inv_all | output | 1 | Invalidate whole D-TLB |
| dtlb_inv_entry | output | 1 | Invalidate one D-TLB entry |
| maint_addr | output | 32 | Address for per-line and per-entry commands |
| illegal_op | output | 1 | Unlisted maintenance combination |

## Verification
On every cycle, the assertions check the following. Stored registers and the control outputs hold steady when no write lands on them. A command pulse or illegal flag always follows a write and clears itself. A line command always carries the address written with it. An unknown read returns zero, and read data holds between reads. The bench scenarios cover what a property cannot express without copying the decode table: the exact mask and reset value of each register, the opcode_2 slot selection, and the pulse chosen by each of the listed maintenance combinations, including the accepted no-op and the duplicate D-cache invalidate.

// File: rtl/mmu_cp_pkg.sv
// Package: constants, register numbers, storage slots and command bit indices
// for the MMU coprocessor control register file.
// Assumes 32-bit coprocessor data and 4-bit register numbers.
package mmu_cp_pkg;

    localparam int DATA_W = 32;
    localparam int REG_W  = 4;
    localparam int OPC_W  = 3;
    localparam int CRM_W  = 4;

    // Register numbers that the core decodes
    localparam logic [REG_W-1:0] RN_ID    = 4'd0;
    localparam logic [REG_W-1:0] RN_CTRL  = 4'd1;
    localparam logic [REG_W-1:0] RN_TTB   = 4'd2;
    localparam logic [REG_W-1:0] RN_DOM   = 4'd3;
    localparam logic [REG_W-1:0] RN_FSTAT = 4'd5;
    localparam logic [REG_W-1:0] RN_FADDR = 4'd6;
    localparam logic [REG_W-1:0] RN_CACHE = 4'd7;
    localparam logic [REG_W-1:0] RN_TLB   = 4'd8;
    localparam logic [REG_W-1:0] RN_PID   = 4'd13;
    localparam logic [REG_W-1:0] RN_CPACC = 4'd15;

    localparam logic [DATA_W-1:0] CACHE_TYPE_VAL = 32'h0B1A_A1AA;

    // Storage slots
    localparam int NSLOT   = 8;
    localparam int SLOT_W  = $clog2(NSLOT);
    localparam int SL_CTRL = 0;
    localparam int SL_AUX  = 1;
    localparam int SL_TTB  = 2;
    localparam int SL_DOM  = 3;
    localparam int SL_FST  = 4;
    localparam int SL_FAD  = 5;
    localparam int SL_PID  = 6;
    localparam int SL_CPA  = 7;

    // Command pulse bit indices
    localparam int CMD_W      = 10;
    localparam int C_IC_ALL   = 0;
    localparam int C_IC_LINE  = 1;
    localparam int C_DC_ALL   = 2;
    localparam int C_DC_LINE  = 3;
    localparam int C_DC_CLEAN = 4;
    localparam int C_WB_DRAIN = 5;
    localparam int C_ITLB_ALL = 6;
    localparam int C_ITLB_ENT = 7;
    localparam int C_DTLB_ALL = 8;
    localparam int C_DTLB_ENT = 9;

    localparam logic [CMD_W-1:0] LINE_CMDS =
        (CMD_W'(1) << C_IC_LINE) | (CMD_W'(1) << C_DC_LINE) |
        (CMD_W'(1) << C_DC_CLEAN) | (CMD_W'(1) << C_ITLB_ENT) |
        (CMD_W'(1) << C_DTLB_ENT);

    // Architected bits kept by each slot
    function automatic logic [DATA_W-1:0] slot_mask(input int s);
        case (s)
            SL_CTRL: slot_mask = 32'h0000_3FFF;
            SL_AUX:  slot_mask = 32'h0000_0033;
            SL_TTB:  slot_mask = 32'hFFFF_C000;
            SL_FST:  slot_mask = 32'h0000_06FF;
            SL_PID:  slot_mask = 32'hFE00_0000;
            SL_CPA:  slot_mask = 32'h0000_03FF;
            default: slot_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    // Reset value of each slot
    function automatic logic [DATA_W-1:0] slot_reset(input int s);
        case (s)
            SL_TTB, SL_DOM: slot_reset = 32'hDEAD_C0DE;
            default:        slot_reset = '0;
        endcase
    endfunction

endpackage

// File: rtl/mmu_reg_bank.sv
// Module: mmu_reg_bank
// Maps a register number and opcode_2 to a storage slot and keeps one masked
// register per slot. Assumes writes are single-cycle strobes.
module mmu_reg_bank
    import mmu_cp_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [REG_W-1:0]               reg_num,
    input  logic [OPC_W-1:0]               opc2,
    input  logic                           wr_en,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NSLOT-1:0][DATA_W-1:0]   slot_q
);

    logic              wr_hit;
    logic [SLOT_W-1:0] wr_slot;

    // Select the slot that a write lands in, if any
    always_comb begin
        wr_hit  = 1'b1;
        wr_slot = SLOT_W'(SL_CTRL);
        case (reg_num)
            RN_CTRL:  wr_slot = (opc2 != '0) ? SLOT_W'(SL_AUX) : SLOT_W'(SL_CTRL);
            RN_TTB:   wr_slot = SLOT_W'(SL_TTB);
            RN_DOM:   wr_slot = SLOT_W'(SL_DOM);
            RN_FSTAT: wr_slot = SLOT_W'(SL_FST);
            RN_FADDR: wr_slot = SLOT_W'(SL_FAD);
            RN_PID:   wr_slot = SLOT_W'(SL_PID);
            RN_CPACC: wr_slot = SLOT_W'(SL_CPA);
            default:  wr_hit  = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        // Hold one register, loading its masked bits on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= slot_reset(g);
            else if (wr_en && wr_hit && (wr_slot == SLOT_W'(g)))
                slot_q[g] <= wr_data & slot_mask(g);
        end
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_hit) |=> $stable(slot_q)); // R8

endmodule

// File: rtl/mmu_maint_decode.sv
// Module: mmu_maint_decode
// Turns writes to the cache and TLB maintenance numbers into registered
// one-cycle command pulses, a line address and an illegal-combination flag.
// Assumes wr_en is a single-cycle strobe.
module mmu_maint_decode
    import mmu_cp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   reg_num,
    input  logic [OPC_W-1:0]   opc2,
    input  logic [CRM_W-1:0]   crm,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [CMD_W-1:0]   cmd,
    output logic [DATA_W-1:0]  maint_addr,
    output logic               illegal_op
);

    logic [CMD_W-1:0] cmd_d;
    logic             ill_d;

    // Decode {opcode_2, CRm} for the two maintenance register numbers
    always_comb begin
        cmd_d = '0;
        ill_d = 1'b0;
        if (wr_en && reg_num == RN_CACHE) begin
            case ({opc2, crm})
                {3'd0, 4'h7}: begin
                    cmd_d[C_IC_ALL] = 1'b1;
                    cmd_d[C_DC_ALL] = 1'b1;
                end
                {3'd0, 4'h5}: cmd_d[C_IC_ALL]   = 1'b1;
                {3'd1, 4'h5}: cmd_d[C_IC_LINE]  = 1'b1;
                {3'd0, 4'h6}: cmd_d[C_DC_ALL]   = 1'b1;
                {3'd1, 4'h6}: cmd_d[C_DC_LINE]  = 1'b1;
                {3'd1, 4'hA}: cmd_d[C_DC_CLEAN] = 1'b1;
                {3'd4, 4'hA}: cmd_d[C_WB_DRAIN] = 1'b1;
                {3'd5, 4'h2}: cmd_d[C_DC_ALL]   = 1'b1;
                {3'd6, 4'h5}: cmd_d = '0;
                default:      ill_d = 1'b1;
            endcase
        end else if (wr_en && reg_num == RN_TLB) begin
            case ({opc2, crm})
                {3'd0, 4'h7}: begin
                    cmd_d[C_ITLB_ALL] = 1'b1;
                    cmd_d[C_DTLB_ALL] = 1'b1;
                end
                {3'd0, 4'h5}: cmd_d[C_ITLB_ALL] = 1'b1;
                {3'd1, 4'h5}: cmd_d[C_ITLB_ENT] = 1'b1;
                {3'd0, 4'h6}: cmd_d[C_DTLB_ALL] = 1'b1;
                {3'd1, 4'h6}: cmd_d[C_DTLB_ENT] = 1'b1;
                default:      ill_d = 1'b1;
            endcase
        end
    end

    // Register the pulses so they last exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd        <= '0;
            illegal_op <= 1'b0;
        end else begin
            cmd        <= cmd_d;
            illegal_op <= ill_d;
        end
    end

    // Capture the address alongside any per-line or per-entry command
    always_ff @(posedge clk) begin
        if (!rst_n)
            maint_addr <= '0;
        else if ((cmd_d & LINE_CMDS) != '0)
            maint_addr <= wr_data;
    end

    AST_PULSE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != '0 || illegal_op) |-> $past(wr_en)); // R11
    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != '0 && !wr_en) |=> (cmd == '0 && !illegal_op)); // R11
    AST_LINE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd & LINE_CMDS) != '0) |-> maint_addr == $past(wr_data)); // R7
    AST_ILLEGAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> ($past(reg_num) == RN_CACHE || $past(reg_num) == RN_TLB)); // R9
    AST_CMD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd) <= 2); // R4

endmodule

// File: rtl/mmu_rd_mux.sv
// Module: mmu_rd_mux
// Selects read data by register number and opcode_2 and registers it on a
// read strobe. Assumes slot contents come from mmu_reg_bank.
module mmu_rd_mux
    import mmu_cp_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [REG_W-1:0]               reg_num,
    input  logic [OPC_W-1:0]               opc2,
    input  logic                           rd_en,
    input  logic [DATA_W-1:0]              core_id,
    input  logic [NSLOT-1:0][DATA_W-1:0]   slot_q,
    output logic [DATA_W-1:0]              rd_data
);

    logic [DATA_W-1:0] rd_d;
    logic              rd_known;

    // Pick the source of a read; unknown and write-only numbers give zero
    always_comb begin
        rd_known = 1'b1;
        rd_d     = '0;
        case (reg_num)
            RN_ID:    rd_d = (opc2 != '0) ? CACHE_TYPE_VAL : core_id;
            RN_CTRL:  rd_d = (opc2 != '0) ? slot_q[SL_AUX] : slot_q[SL_CTRL];
            RN_TTB:   rd_d = slot_q[SL_TTB];
            RN_DOM:   rd_d = slot_q[SL_DOM];
            RN_FSTAT: rd_d = slot_q[SL_FST];
            RN_FADDR: rd_d = slot_q[SL_FAD];
            RN_PID:   rd_d = slot_q[SL_PID];
            RN_CPACC: rd_d = slot_q[SL_CPA];
            default:  rd_known = 1'b0;
        endcase
    end

    // Register read data on a strobe and hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_d;
    end

    AST_UNKNOWN_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_known) |=> rd_data == '0); // R8
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11

endmodule

// File: rtl/mmu_ctrl_regs.sv
// Module: mmu_ctrl_regs (top)
// MMU coprocessor control register file: masked register storage, read
// selection, maintenance command decode and control-bit outputs.
// Assumes one access per cycle driven by the core's coprocessor interface.
module mmu_ctrl_regs
    import mmu_cp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_W-1:0]   reg_num,
    input  logic [OPC_W-1:0]   opc2,
    input  logic [CRM_W-1:0]   crm,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [DATA_W-1:0]  core_id,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mmu_en,
    output logic               align_en,
    output logic               dcache_en,
    output logic               ic_inv_all,
    output logic               ic_inv_line,
    output logic               dc_inv_all,
    output logic               dc_inv_line,
    output logic               dc_clean_line,
    output logic               wb_drain,
    output logic               itlb_inv_all,
    output logic               itlb_inv_entry,
    output logic               dtlb_inv_all,
    output logic               dtlb_inv_entry,
    output logic [DATA_W-1:0]  maint_addr,
    output logic               illegal_op
);

    logic [NSLOT-1:0][DATA_W-1:0] slot_q;
    logic [CMD_W-1:0]             cmd;

    mmu_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_num (reg_num),
        .opc2    (opc2),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .slot_q  (slot_q)
    );

    mmu_rd_mux u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_num (reg_num),
        .opc2    (opc2),
        .rd_en   (rd_en),
        .core_id (core_id),
        .slot_q  (slot_q),
        .rd_data (rd_data)
    );

    mmu_maint_decode u_maint (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_num    (reg_num),
        .opc2       (opc2),
        .crm        (crm),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cmd        (cmd),
        .maint_addr (maint_addr),
        .illegal_op (illegal_op)
    );

    // Drive the control-bit outputs from the main control register
    always_comb begin
        mmu_en    = slot_q[SL_CTRL][0];
        align_en  = slot_q[SL_CTRL][1];
        dcache_en = slot_q[SL_CTRL][2];
    end

    // Fan the command vector out to named pulses
    always_comb begin
        ic_inv_all     = cmd[C_IC_ALL];
        ic_inv_line    = cmd[C_IC_LINE];
        dc_inv_all     = cmd[C_DC_ALL];
        dc_inv_line    = cmd[C_DC_LINE];
        dc_clean_line  = cmd[C_DC_CLEAN];
        wb_drain       = cmd[C_WB_DRAIN];
        itlb_inv_all   = cmd[C_ITLB_ALL];
        itlb_inv_entry = cmd[C_ITLB_ENT];
        dtlb_inv_all   = cmd[C_DTLB_ALL];
        dtlb_inv_entry = cmd[C_DTLB_ENT];
    end

    AST_CTRL_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_num == RN_CTRL) |=> $stable({mmu_en, align_en, dcache_en})); // R10

endmodule

// File: tb/mmu_ctrl_regs_tb.sv
// Testbench for mmu_ctrl_regs: vector table of write/read-back pairs, then
// directed tests for reset, slot selection, maintenance decode and corners.
module mmu_ctrl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [2:0]  opc2 = '0;
    logic [3:0]  crm = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] core_id = 32'h6905_2104;
    logic [31:0] rd_data;
    logic        mmu_en, align_en, dcache_en;
    logic        ic_inv_all, ic_inv_line, dc_inv_all, dc_inv_line, dc_clean_line;
    logic        wb_drain, itlb_inv_all, itlb_inv_entry, dtlb_inv_all, dtlb_inv_entry;
    logic [31:0] maint_addr;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mmu_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_num(reg_num), .opc2(opc2), .crm(crm),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .core_id(core_id),
        .rd_data(rd_data), .mmu_en(mmu_en), .align_en(align_en), .dcache_en(dcache_en),
        .ic_inv_all(ic_inv_all), .ic_inv_line(ic_inv_line), .dc_inv_all(dc_inv_all),
        .dc_inv_line(dc_inv_line), .dc_clean_line(dc_clean_line), .wb_drain(wb_drain),
        .itlb_inv_all(itlb_inv_all), .itlb_inv_entry(itlb_inv_entry),
        .dtlb_inv_all(dtlb_inv_all), .dtlb_inv_entry(dtlb_inv_entry),
        .maint_addr(maint_addr), .illegal_op(illegal_op)
    );

    typedef struct packed {
        logic [3:0]  rn;
        logic [2:0]  op;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    // Write then read back; expected values follow the masks of R1 and R2
    localparam vec_t VECS [8] = '{
        '{4'd1,  3'd0, 32'hFFFF_FFFF, 32'h0000_3FFF},
        '{4'd1,  3'd1, 32'hFFFF_FFFF, 32'h0000_0033},
        '{4'd2,  3'd0, 32'hFFFF_FFFF, 32'hFFFF_C000},
        '{4'd3,  3'd0, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
        '{4'd5,  3'd0, 32'hFFFF_FFFF, 32'h0000_06FF},
        '{4'd6,  3'd0, 32'h1234_5678, 32'h1234_5678},
        '{4'd13, 3'd0, 32'hFFFF_FFFF, 32'hFE00_0000},
        '{4'd15, 3'd0, 32'hFFFF_FFFF, 32'h0000_03FF}
    };

    function automatic logic [9:0] cmd_vec();
        return {ic_inv_all, ic_inv_line, dc_inv_all, dc_inv_line, dc_clean_line,
                wb_drain, itlb_inv_all, itlb_inv_entry, dtlb_inv_all, dtlb_inv_entry};
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] rn, input logic [2:0] op,
                            input logic [3:0] cm, input logic [31:0] d);
        @(negedge clk);
        reg_num = rn; opc2 = op; crm = cm; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] rn, input logic [2:0] op);
        @(negedge clk);
        reg_num = rn; opc2 = op; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [3:0] rn,
                              input logic [2:0] op, input logic [31:0] exp);
        do_read(rn, op);
        check32(req, rd_data, exp);
    endtask

    // Issue a maintenance write and check the pulse vector, flag and address
    task automatic maint(input string req, input logic [3:0] rn, input logic [2:0] op,
                         input logic [3:0] cm, input logic [31:0] d,
                         input logic [9:0] exp_cmd, input logic exp_ill, input logic line);
        do_write(rn, op, cm, d);
        check32(req, {22'd0, cmd_vec()}, {22'd0, exp_cmd});
        check32(req, {31'd0, illegal_op}, {31'd0, exp_ill});
        if (line) check32("R7", maint_addr, d);
        @(negedge clk);
        check32("R11", {21'd0, cmd_vec(), illegal_op}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset values
        check32("R3 ctrl outputs", {29'd0, mmu_en, align_en, dcache_en}, 32'd0);
        check32("R3 rd_data", rd_data, 32'd0);
        read_check("R3 ttb", 4'd2, 3'd0, 32'hDEAD_C0DE);
        read_check("R3 dom", 4'd3, 3'd0, 32'hDEAD_C0DE);
        read_check("R3 ctrl", 4'd1, 3'd0, 32'h0);
        read_check("R3 aux", 4'd1, 3'd2, 32'h0);
        read_check("R3 fstat", 4'd5, 3'd0, 32'h0);
        read_check("R3 pid", 4'd13, 3'd0, 32'h0);

        // R1: identification slot selection
        read_check("R1 id", 4'd0, 3'd0, 32'h6905_2104);
        read_check("R1 cache type", 4'd0, 3'd1, 32'h0B1A_A1AA);
        read_check("R1 cache type op7", 4'd0, 3'd7, 32'h0B1A_A1AA);

        // R2: masked write/read-back table
        for (int i = 0; i < 8; i++) begin
            do_write(VECS[i].rn, VECS[i].op, 4'd0, VECS[i].wd);
            read_check("R2 mask", VECS[i].rn, VECS[i].op, VECS[i].exp);
        end
        // R1: aux write left main control untouched
        read_check("R1 ctrl after aux", 4'd1, 3'd0, 32'h0000_3FFF);

        // R11: read data holds between reads
        repeat (3) @(negedge clk);
        check32("R11 rd hold", rd_data, 32'h0000_3FFF);

        // R10: control bits drive outputs
        do_write(4'd1, 3'd0, 4'd0, 32'h0000_0005);
        check32("R10 outputs 101", {29'd0, mmu_en, align_en, dcache_en}, 32'd5);
        do_write(4'd1, 3'd0, 4'd0, 32'h0000_0002);
        check32("R10 outputs 010", {29'd0, mmu_en, align_en, dcache_en}, 32'd2);

        // R4: cache maintenance decode
        maint("R4 inv both caches", 4'd7, 3'd0, 4'h7, 32'h100, 10'b1010000000, 1'b0, 1'b0);
        maint("R4 inv icache",      4'd7, 3'd0, 4'h5, 32'h104, 10'b1000000000, 1'b0, 1'b0);
        maint("R4 inv iline",       4'd7, 3'd1, 4'h5, 32'hC0DE_1000, 10'b0100000000, 1'b0, 1'b1);
        maint("R4 inv dcache",      4'd7, 3'd0, 4'h6, 32'h108, 10'b0010000000, 1'b0, 1'b0);
        maint("R4 inv dline",       4'd7, 3'd1, 4'h6, 32'hBEEF_0020, 10'b0001000000, 1'b0, 1'b1);
        maint("R4 clean dline",     4'd7, 3'd1, 4'hA, 32'h8000_0040, 10'b0000100000, 1'b0, 1'b1);
        maint("R4 drain wb",        4'd7, 3'd4, 4'hA, 32'h10C, 10'b0000010000, 1'b0, 1'b0);
        // R6: accepted no-op and alternative D-cache invalidate
        maint("R6 btb no-op",       4'd7, 3'd6, 4'h5, 32'h110, 10'b0000000000, 1'b0, 1'b0);
        maint("R6 dcache alt",      4'd7, 3'd5, 4'h2, 32'h114, 10'b0010000000, 1'b0, 1'b0);
        // R5: TLB maintenance decode
        maint("R5 inv both tlbs",   4'd8, 3'd0, 4'h7, 32'h118, 10'b0000001010, 1'b0, 1'b0);
        maint("R5 inv itlb",        4'd8, 3'd0, 4'h5, 32'h11C, 10'b0000001000, 1'b0, 1'b0);
        maint("R5 inv itlb entry",  4'd8, 3'd1, 4'h5, 32'h4000_1000, 10'b0000000100, 1'b0, 1'b1);
        maint("R5 inv dtlb",        4'd8, 3'd0, 4'h6, 32'h120, 10'b0000000010, 1'b0, 1'b0);
        maint("R5 inv dtlb entry",  4'd8, 3'd1, 4'h6, 32'h5000_2000, 10'b0000000001, 1'b0, 1'b1);
        // R9: unlisted combinations
        maint("R9 cache unlisted",  4'd7, 3'd3, 4'h3, 32'h124, 10'b0000000000, 1'b1, 1'b0);
        maint("R9 tlb btb combo",   4'd8, 3'd6, 4'h5, 32'h128, 10'b0000000000, 1'b1, 1'b0);
        maint("R9 tlb clean combo", 4'd8, 3'd1, 4'hA, 32'h12C, 10'b0000000000, 1'b1, 1'b0);

        // R8: maintenance writes stored nothing; maintenance reads give zero
        read_check("R8 ctrl kept", 4'd1, 3'd0, 32'h0000_0002);
        read_check("R8 read reg7", 4'd7, 3'd0, 32'h0);
        read_check("R8 read reg8", 4'd8, 3'd1, 32'h0);
        // R8: unknown register write ignored, read zero
        do_write(4'd4, 3'd0, 4'd0, 32'hFFFF_FFFF);
        do_write(4'd9, 3'd0, 4'd0, 32'hFFFF_FFFF);
        read_check("R8 read reg4", 4'd4, 3'd0, 32'h0);
        read_check("R8 read reg12", 4'd12, 3'd0, 32'h0);
        read_check("R8 dom kept", 4'd3, 3'd0, 32'hA5A5_5A5A);
        read_check("R8 far kept", 4'd6, 3'd0, 32'h1234_5678);
        check32("R8 outputs kept", {29'd0, mmu_en, align_en, dcache_en}, 32'd2);

        // R3: reset again restores values
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check("R3 ttb after reset", 4'd2, 3'd0, 32'hDEAD_C0DE);
        read_check("R3 far after reset", 4'd6, 3'd0, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule